// File: doc/BRIEF.md
# SPI Controller with Host-Request Handshake

This block moves 24-bit words over a four-wire serial link. It can act as the clock-owning side (master) or as the clocked side (slave). A parallel interface on the core side lets the host write a transmit word, read the last received word and watch four status flags. An active-low host-request line paces the link one word at a time. When the block is the slave, it drives the line low once it has a word ready to shift. When it is the master, it waits for the far side to pull the line low before it starts a word.

In slave mode the incoming clock, select and data are brought into the system clock domain through synchronizer chains. SCK edges seen while select is high are ignored, and during that time the data-out pin is not driven. In master mode the block makes SCK from the system clock with a programmable half-period. It holds its own chip-select output low only for the length of one word. If the select input is pulled low while the block is the master, it raises a sticky bus-error flag.

Top module: `spi_req_link`

## Requirements
- R1: While `rstN` is low, `mosiOe`, `misoOe`, `hreqOe`, `sckOut`, `rxFull`, `overrun` and `busErr` are 0, and `csOutN` and `txEmpty` are 1.
- R2: A `txWrite` pulse stores `txData` and clears `txEmpty` one cycle later. `txEmpty` is set again in the cycle the word is moved into the shifter.
- R3: Master frame: SCK idles low, and each word has exactly 24 rising edges. `mosiOut` presents bit 23 first and changes only after a falling edge. `misoIn` is sampled on each rising edge, MSB first, and the received word appears in `rxData`.
- R4: In master mode, `csOutN` stays low for exactly 48*(`cfgDiv`+1) system clocks per word.
- R5: In master mode with `cfgReqEn` = 0, a pending word starts at once. With either `cfgReqEn` bit set, a word starts only after a new high-to-low transition of `hreqInN`. A request line held low never starts a second word.
- R6: `hreqOe` is 1 only in slave mode with at least one `cfgReqEn` bit set. In slave mode `hreqOutN` goes low once a word is loaded, and goes high again after the first SCK rising edge of that word.
- R7: Slave frame: with `ssInN` low, the 24 bits on `mosiIn` (MSB first, sampled on SCK rise) land in `rxData`, and the loaded word is shifted out on `misoOut`.
- R8: In slave mode with `ssInN` high, `misoOe` is 0 and SCK edges change neither the receive state nor `hreqOutN`.
- R9: `mosiOe` is 1 only in master mode. `misoOe` is 1 only in slave mode with `ssInN` low.
- R10: In master mode a low `ssInN` sets `busErr`. `statClear` clears it.
- R11: A completed word sets `rxFull`, and `rxRead` clears it. A word that completes while `rxFull` is set also sets `overrun`, which `statClear` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMaster | input | 1 | 1 = master, 0 = slave |
| cfgReqEn | input | 2 | Request-line enables; either bit set turns pacing on |
| cfgDiv | input | 8 | SCK half-period minus one, in system clocks |
| txData | input | 24 | Word to transmit |
| txWrite | input | 1 | Store `txData` |
| rxData | output | 24 | Last received word |
| rxRead | input | 1 | Acknowledge the received word |
| statClear | input | 1 | Clear overrun and bus error |
| txEmpty | output | 1 | No transmit word pending |
| rxFull | output | 1 | Unread received word |
| overrun | output | 1 | Word received while one was unread |
| busErr | output | 1 | Select seen low in master mode |
| sckIn | input | 1 | Serial clock from a remote master |
| sckOut | output | 1 | Generated serial clock |
| ssInN | input | 1 | Active-low slave select input |
| csOutN | output | 1 | Active-low select driven in master mode |
| mosiIn | input | 1 | Serial data in, slave mode |
| mosiOut | output | 1 | Serial data out, master mode |
| mosiOe | output | 1 | Drive enable for `mosiOut` |
| misoIn | input | 1 | Serial data in, master mode |
| misoOut | output | 1 | Serial data out, slave mode |
| misoOe | output | 1 | Drive enable for `misoOut` |
| hreqInN | input | 1 | Request from the remote slave |
| hreqOutN | output | 1 | Request to the remote master |
| hreqOe | output | 1 | Drive enable for `hreqOutN` |

## Verification
The bench goes after the pacing corners. A request line held low past the end of a word must not start a second word; a design that tested the level instead of a new assertion would stream words back to back. SCK pulses with select high must leave the receive flags and the request line untouched; a design that failed to gate them would shift garbage and drop its request early. The frame length is measured in system clocks at two divider settings, which catches an off-by-one half period. Words are received back to back without a read to expose a missing overrun, and select is pulled low in master mode to check the bus-error flag and its clear.

// File: rtl/spi_req_pkg.sv
package spi_req_pkg;

  // Per-cycle commands from the control path to the datapath
  typedef struct packed {
    logic loadTx;     // move the holding word into the shifter
    logic shiftTx;    // advance the transmit shifter by one bit
    logic sampleRx;   // take rxBit into the receive shifter
    logic commitRx;   // publish the receive shifter as a word
    logic rxBit;      // bit to take when sampleRx is set
    logic flagBusErr; // select seen low while master
  } strobe_t;

  typedef enum logic {
    M_IDLE = 1'b0,
    M_RUN  = 1'b1
  } mstate_t;

endpackage

// File: rtl/spi_req_sync.sv
module spi_req_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= RST_VAL;
        else       pipe <= d;
      end
    end else begin : gChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= {STAGES{RST_VAL}};
        else       pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_req_ctl.sv
module spi_req_ctl
  import spi_req_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgMaster,
  input  logic [1:0]       cfgReqEn,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             txEmpty,
  input  logic             sckIn,
  input  logic             ssInN,
  input  logic             mosiIn,
  input  logic             misoIn,
  input  logic             hreqInN,
  output strobe_t          str,
  output logic             sckOut,
  output logic             csOutN,
  output logic             hreqOutN,
  output logic             hreqOe,
  output logic             misoOe,
  output logic             mosiOe
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic sckS, ssS, mosiS, hreqS;
  logic sckPrev, hreqPrev;

  spi_req_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) uSck  (.clk(clk), .rstN(rstN), .d(sckIn),   .q(sckS));
  spi_req_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uSs   (.clk(clk), .rstN(rstN), .d(ssInN),   .q(ssS));
  spi_req_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) uMosi (.clk(clk), .rstN(rstN), .d(mosiIn),  .q(mosiS));
  spi_req_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uHreq (.clk(clk), .rstN(rstN), .d(hreqInN), .q(hreqS));

  logic ssActive, sckRise, sckFall, hreqFall, reqOn, tick, startM;
  assign ssActive = !ssS;
  assign sckRise  = sckS && !sckPrev;
  assign sckFall  = !sckS && sckPrev;
  assign hreqFall = hreqPrev && !hreqS;
  assign reqOn    = |cfgReqEn;

  mstate_t          mState;
  logic [CNT_W-1:0] bitCnt;
  logic [DIV_W-1:0] divCnt;
  logic             armed, sckR, csN, reqPend;
  logic             hreqOeR, misoOeR, mosiOeR;

  assign tick = (divCnt == cfgDiv);

  // Strobe decode
  always_comb begin
    str            = '0;
    str.rxBit      = cfgMaster ? misoIn : mosiS;
    str.flagBusErr = cfgMaster && ssActive;
    startM         = 1'b0;
    if (cfgMaster) begin
      if (mState == M_IDLE) begin
        startM     = !txEmpty && (!reqOn || reqPend);
        str.loadTx = startM;
      end else if (tick) begin
        if (!sckR)                  str.sampleRx = 1'b1;
        else if (bitCnt == CNT_FULL) str.commitRx = 1'b1;
        else                        str.shiftTx  = 1'b1;
      end
    end else begin
      if (ssActive && sckRise) begin
        str.sampleRx = 1'b1;
        str.commitRx = (bitCnt == CNT_LAST);
      end else if (ssActive && sckFall && bitCnt != '0) begin
        str.shiftTx = 1'b1;
      end
      if (bitCnt == '0 && !armed && !txEmpty && !(ssActive && sckRise))
        str.loadTx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev  <= 1'b0;
      hreqPrev <= 1'b1;
      mState   <= M_IDLE;
      bitCnt   <= '0;
      divCnt   <= '0;
      armed    <= 1'b0;
      sckR     <= 1'b0;
      csN      <= 1'b1;
      reqPend  <= 1'b0;
      hreqOeR  <= 1'b0;
      misoOeR  <= 1'b0;
      mosiOeR  <= 1'b0;
    end else begin
      sckPrev  <= sckS;
      hreqPrev <= hreqS;
      hreqOeR  <= !cfgMaster && reqOn;
      misoOeR  <= !cfgMaster && ssActive;
      mosiOeR  <= cfgMaster;
      if (cfgMaster) begin
        armed <= 1'b0;
        if (reqOn && hreqFall) reqPend <= 1'b1;
        if (mState == M_IDLE) begin
          bitCnt <= '0;
          divCnt <= '0;
          sckR   <= 1'b0;
          if (startM) begin
            mState  <= M_RUN;
            csN     <= 1'b0;
            reqPend <= 1'b0;
          end
        end else begin
          divCnt <= tick ? '0 : divCnt + 1'b1;
          if (tick) begin
            if (!sckR) begin
              sckR   <= 1'b1;
              bitCnt <= bitCnt + 1'b1;
            end else begin
              sckR <= 1'b0;
              if (bitCnt == CNT_FULL) begin
                mState <= M_IDLE;
                csN    <= 1'b1;
              end
            end
          end
        end
      end else begin
        mState  <= M_IDLE;
        csN     <= 1'b1;
        sckR    <= 1'b0;
        divCnt  <= '0;
        reqPend <= 1'b0;
        if (!ssActive) begin
          bitCnt <= '0;
        end else if (sckRise) begin
          armed  <= 1'b0;
          bitCnt <= (bitCnt == CNT_LAST) ? '0 : bitCnt + 1'b1;
        end
        if (str.loadTx) armed <= 1'b1;
      end
    end
  end

  assign sckOut   = sckR;
  assign csOutN   = csN;
  assign hreqOutN = !armed;
  assign hreqOe   = hreqOeR;
  assign misoOe   = misoOeR;
  assign mosiOe   = mosiOeR;

endmodule

// File: rtl/spi_req_dp.sv
module spi_req_dp
  import spi_req_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           str,
  input  logic [WORD_W-1:0] txData,
  input  logic              txWrite,
  input  logic              rxRead,
  input  logic              statClear,
  output logic              txBit,
  output logic [WORD_W-1:0] rxData,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              overrun,
  output logic              busErr
);

  logic [WORD_W-1:0] txHold, txShift, rxShift, rxNext;

  assign rxNext = str.sampleRx ? {rxShift[WORD_W-2:0], str.rxBit} : rxShift;
  assign txBit  = txShift[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold  <= '0;
      txShift <= '0;
      rxShift <= '0;
      rxData  <= '0;
      txEmpty <= 1'b1;
      rxFull  <= 1'b0;
      overrun <= 1'b0;
      busErr  <= 1'b0;
    end else begin
      if (str.loadTx)       txShift <= txHold;
      else if (str.shiftTx) txShift <= {txShift[WORD_W-2:0], 1'b0};

      if (txWrite) begin
        txHold  <= txData;
        txEmpty <= 1'b0;
      end else if (str.loadTx) begin
        txEmpty <= 1'b1;
      end

      rxShift <= rxNext;
      if (str.commitRx) begin
        rxData <= rxNext;
        rxFull <= 1'b1;
      end else if (rxRead) begin
        rxFull <= 1'b0;
      end

      if (str.commitRx && rxFull && !rxRead) overrun <= 1'b1;
      else if (statClear)                    overrun <= 1'b0;

      if (str.flagBusErr)  busErr <= 1'b1;
      else if (statClear)  busErr <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_req_link.sv
module spi_req_link
  import spi_req_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgMaster,
  input  logic [1:0]        cfgReqEn,
  input  logic [DIV_W-1:0]  cfgDiv,
  input  logic [WORD_W-1:0] txData,
  input  logic              txWrite,
  output logic [WORD_W-1:0] rxData,
  input  logic              rxRead,
  input  logic              statClear,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              overrun,
  output logic              busErr,
  input  logic              sckIn,
  output logic              sckOut,
  input  logic              ssInN,
  output logic              csOutN,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              hreqInN,
  output logic              hreqOutN,
  output logic              hreqOe
);

  strobe_t ctlStr;
  logic    txBit;

  spi_req_ctl #(
    .WORD_W(WORD_W), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)
  ) uCtl (
    .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgReqEn(cfgReqEn),
    .cfgDiv(cfgDiv), .txEmpty(txEmpty), .sckIn(sckIn), .ssInN(ssInN),
    .mosiIn(mosiIn), .misoIn(misoIn), .hreqInN(hreqInN), .str(ctlStr),
    .sckOut(sckOut), .csOutN(csOutN), .hreqOutN(hreqOutN), .hreqOe(hreqOe),
    .misoOe(misoOe), .mosiOe(mosiOe)
  );

  spi_req_dp #(.WORD_W(WORD_W)) uDp (
    .clk(clk), .rstN(rstN), .str(ctlStr), .txData(txData), .txWrite(txWrite),
    .rxRead(rxRead), .statClear(statClear), .txBit(txBit), .rxData(rxData),
    .txEmpty(txEmpty), .rxFull(rxFull), .overrun(overrun), .busErr(busErr)
  );

  assign mosiOut = txBit;
  assign misoOut = txBit;

endmodule

// File: rtl/spi_req_chk.sv
module spi_req_chk
  import spi_req_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    cfgMaster,
  input logic    txWrite,
  input logic    txEmpty,
  input logic    rxFull,
  input logic    overrun,
  input logic    busErr,
  input logic    sckOut,
  input logic    csOutN,
  input logic    misoOe,
  input logic    mosiOe,
  input logic    hreqOe,
  input strobe_t ctlStr
);

  p_sck_inside_cs_r3: assert property (@(posedge clk) disable iff (!rstN)
    sckOut |-> !csOutN);

  p_cs_master_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    !csOutN |-> $past(cfgMaster));

  p_load_empties_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctlStr.loadTx && !txWrite) |=> txEmpty);

  p_hreq_drive_slave_r6: assert property (@(posedge clk) disable iff (!rstN)
    hreqOe |-> !$past(cfgMaster));

  p_oe_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(misoOe && mosiOe));

  p_buserr_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctlStr.flagBusErr |=> busErr);

  p_full_from_commit_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> $past(ctlStr.commitRx));

  p_overrun_needs_full_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> ($past(rxFull) && $past(ctlStr.commitRx)));

endmodule

bind spi_req_link spi_req_chk uChk (
  .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .txWrite(txWrite),
  .txEmpty(txEmpty), .rxFull(rxFull), .overrun(overrun), .busErr(busErr),
  .sckOut(sckOut), .csOutN(csOutN), .misoOe(misoOe), .mosiOe(mosiOe),
  .hreqOe(hreqOe), .ctlStr(ctlStr)
);

// File: tb/tb_spi_req_link.sv
module tb_spi_req_link;

  localparam int CLK_PERIOD = 10;
  localparam int HP         = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgMaster = 1'b1;
  logic [1:0]  cfgReqEn = 2'b00;
  logic [7:0]  cfgDiv = 8'd1;
  logic [23:0] txData = '0;
  logic        txWrite = 1'b0;
  logic [23:0] rxData;
  logic        rxRead = 1'b0;
  logic        statClear = 1'b0;
  logic        txEmpty, rxFull, overrun, busErr;
  logic        sckIn = 1'b0;
  logic        sckOut;
  logic        ssInN = 1'b1;
  logic        csOutN;
  logic        mosiIn = 1'b0;
  logic        mosiOut, mosiOe;
  logic        misoIn = 1'b0;
  logic        misoOut, misoOe;
  logic        hreqInN = 1'b1;
  logic        hreqOutN, hreqOe;

  int checks = 0;
  int fails  = 0;

  // Behavioural reference state
  logic [23:0] expRxQ[$];
  int          mRxFull = 0;
  int          mOverrun = 0;
  logic        monOn = 1'b0;
  logic        expMosiOe = 1'b0, expMisoOe = 1'b0, expHreqOe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_req_link dut (
    .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgReqEn(cfgReqEn),
    .cfgDiv(cfgDiv), .txData(txData), .txWrite(txWrite), .rxData(rxData),
    .rxRead(rxRead), .statClear(statClear), .txEmpty(txEmpty), .rxFull(rxFull),
    .overrun(overrun), .busErr(busErr), .sckIn(sckIn), .sckOut(sckOut),
    .ssInN(ssInN), .csOutN(csOutN), .mosiIn(mosiIn), .mosiOut(mosiOut),
    .mosiOe(mosiOe), .misoIn(misoIn), .misoOut(misoOut), .misoOe(misoOe),
    .hreqInN(hreqInN), .hreqOutN(hreqOutN), .hreqOe(hreqOe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // Clock-by-clock comparison of the drive enables against the model
  always @(negedge clk) begin
    if (monOn) begin
      chk("R9 mosiOe", 32'(mosiOe), 32'(expMosiOe));
      chk("R9 misoOe", 32'(misoOe), 32'(expMisoOe));
      chk("R6 hreqOe", 32'(hreqOe), 32'(expHreqOe));
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeTx(input logic [23:0] w);
    txData  = w;
    txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
  endtask

  task automatic pulseRead();
    rxRead = 1'b1;
    @(negedge clk);
    rxRead = 1'b0;
    mRxFull = 0;
  endtask

  task automatic pulseClear();
    statClear = 1'b1;
    @(negedge clk);
    statClear = 1'b0;
    mOverrun = 0;
  endtask

  // Bench plays the remote slave while the block is master
  task automatic actSlave(input logic [23:0] so, output logic [23:0] got,
                          output int rises, output int lowCycles);
    int   guard;
    int   bitIdx;
    logic prevSck;
    got = '0; rises = 0; lowCycles = 0; guard = 0;
    while (csOutN === 1'b1 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    bitIdx  = 23;
    misoIn  = so[23];
    prevSck = 1'b0;
    while (csOutN === 1'b0 && guard < 40000) begin
      lowCycles++;
      if (sckOut && !prevSck) begin
        got = {got[22:0], mosiOut};
        rises++;
      end
      if (!sckOut && prevSck) begin
        if (bitIdx > 0) bitIdx--;
        misoIn = so[bitIdx];
      end
      prevSck = sckOut;
      guard++;
      @(negedge clk);
    end
    if (mRxFull != 0) mOverrun = 1;
    mRxFull = 1;
    expRxQ.push_back(so);
  endtask

  // Bench plays the remote master while the block is slave
  task automatic drvMaster(input logic [23:0] mo, output logic [23:0] mi,
                           output logic oeSeen, output logic hreqAfter);
    mi = '0;
    hreqAfter = 1'b0;
    ssInN = 1'b0;
    waitClk(HP);
    oeSeen = misoOe;
    for (int i = 23; i >= 0; i--) begin
      mosiIn = mo[i];
      waitClk(HP);
      mi[i] = misoOut;
      sckIn = 1'b1;
      waitClk(HP);
      if (i == 23) hreqAfter = hreqOutN;
      sckIn = 1'b0;
    end
    waitClk(HP);
    ssInN = 1'b1;
    waitClk(HP);
    if (mRxFull != 0) mOverrun = 1;
    mRxFull = 1;
    expRxQ.push_back(mo);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish (all requirements)");
    summary();
    $finish;
  end

  initial begin
    logic [23:0] got, mi, expW;
    int          rises, lowCycles;
    logic        oeSeen, hreqAfter;

    // ---- R1 reset state ----
    waitClk(3);
    chk("R1 mosiOe", 32'(mosiOe), 0);
    chk("R1 misoOe", 32'(misoOe), 0);
    chk("R1 hreqOe", 32'(hreqOe), 0);
    chk("R1 csOutN", 32'(csOutN), 1);
    chk("R1 sckOut", 32'(sckOut), 0);
    chk("R1 txEmpty", 32'(txEmpty), 1);
    chk("R1 flags", {29'd0, rxFull, overrun, busErr}, 0);
    rstN = 1'b1;
    waitClk(3);
    expMosiOe = 1'b1; expMisoOe = 1'b0; expHreqOe = 1'b0;
    monOn = 1'b1;

    // ---- R3 R4 master frame, no pacing ----
    cfgDiv = 8'd1;
    writeTx(24'hA5C31E);
    actSlave(24'h5B17E2, got, rises, lowCycles);
    chk("R3 master mosi word", 32'(got), 32'h00A5C31E);
    chk("R3 rising edges", 32'(rises), 24);
    chk("R4 cs low cycles div1", 32'(lowCycles), 48 * 2);
    expW = expRxQ.pop_front();
    chk("R3 rxData master", 32'(rxData), 32'(expW));
    chk("R11 rxFull set", 32'(rxFull), 32'(mRxFull));
    chk("R2 txEmpty after send", 32'(txEmpty), 1);
    pulseRead();
    chk("R11 rxFull cleared", 32'(rxFull), 32'(mRxFull));

    // ---- R4 second divider, then R11 overrun ----
    cfgDiv = 8'd3;
    writeTx(24'h0F0F0F);
    actSlave(24'hC0FFEE, got, rises, lowCycles);
    chk("R4 cs low cycles div3", 32'(lowCycles), 48 * 4);
    chk("R3 master mosi word 2", 32'(got), 32'h000F0F0F);
    expW = expRxQ.pop_front();
    chk("R3 rxData master 2", 32'(rxData), 32'(expW));
    cfgDiv = 8'd0;
    writeTx(24'h800001);
    actSlave(24'h123456, got, rises, lowCycles);
    expW = expRxQ.pop_front();
    chk("R11 rxData overwritten", 32'(rxData), 32'(expW));
    chk("R11 overrun set", 32'(overrun), 32'(mOverrun));
    chk("R4 cs low cycles div0", 32'(lowCycles), 48);
    pulseClear();
    chk("R11 overrun cleared", 32'(overrun), 32'(mOverrun));
    pulseRead();

    // ---- R5 request pacing in master mode ----
    cfgDiv   = 8'd1;
    cfgReqEn = 2'b10;
    waitClk(2);
    writeTx(24'h6699AA);
    waitClk(200);
    chk("R5 no start without request", 32'(csOutN), 1);
    chk("R5 word still pending", 32'(txEmpty), 0);
    hreqInN = 1'b0;
    actSlave(24'h00FF00, got, rises, lowCycles);
    chk("R5 word after request", 32'(got), 32'h006699AA);
    expW = expRxQ.pop_front();
    chk("R5 rx after request", 32'(rxData), 32'(expW));
    pulseRead();
    writeTx(24'h112233);
    waitClk(200);
    chk("R5 held request starts nothing", 32'(csOutN), 1);
    hreqInN = 1'b1;
    waitClk(5);
    hreqInN = 1'b0;
    actSlave(24'hABCDEF, got, rises, lowCycles);
    chk("R5 word after new request", 32'(got), 32'h00112233);
    expW = expRxQ.pop_front();
    chk("R5 rx after new request", 32'(rxData), 32'(expW));
    pulseRead();
    hreqInN = 1'b1;

    // ---- R10 bus error ----
    chk("R10 busErr idle", 32'(busErr), 0);
    ssInN = 1'b0;
    waitClk(5);
    chk("R10 busErr set", 32'(busErr), 1);
    ssInN = 1'b1;
    waitClk(5);
    pulseClear();
    chk("R10 busErr cleared", 32'(busErr), 0);

    // ---- switch to slave mode ----
    monOn     = 1'b0;
    cfgMaster = 1'b0;
    cfgReqEn  = 2'b01;
    waitClk(5);
    expMosiOe = 1'b0; expMisoOe = 1'b0; expHreqOe = 1'b1;
    monOn = 1'b1;
    chk("R6 hreq idle high", 32'(hreqOutN), 1);

    // ---- R2 load timing ----
    txData  = 24'hDEAD5A;
    txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
    chk("R2 txEmpty cleared", 32'(txEmpty), 0);
    @(negedge clk);
    chk("R2 txEmpty after load", 32'(txEmpty), 1);
    chk("R6 hreq low when loaded", 32'(hreqOutN), 0);

    // ---- R8 edges ignored with select high ----
    for (int k = 0; k < 24; k++) begin
      sckIn = 1'b1; waitClk(HP);
      sckIn = 1'b0; waitClk(HP);
    end
    waitClk(4);
    chk("R8 no receive", 32'(rxFull), 0);
    chk("R8 hreq unchanged", 32'(hreqOutN), 0);
    chk("R8 miso undriven", 32'(misoOe), 0);

    // ---- R7 slave frame ----
    monOn = 1'b0;
    drvMaster(24'h3C96F1, mi, oeSeen, hreqAfter);
    chk("R9 misoOe with select low", 32'(oeSeen), 1);
    chk("R6 hreq high after first edge", 32'(hreqAfter), 1);
    chk("R7 miso word", 32'(mi), 32'h00DEAD5A);
    expW = expRxQ.pop_front();
    chk("R7 rxData slave", 32'(rxData), 32'(expW));
    chk("R11 rxFull slave", 32'(rxFull), 32'(mRxFull));
    chk("R8 miso released", 32'(misoOe), 0);
    pulseRead();

    // ---- R6 request disabled, second slave word ----
    cfgReqEn = 2'b00;
    waitClk(3);
    expHreqOe = 1'b0;
    monOn = 1'b1;
    chk("R6 hreqOe off", 32'(hreqOe), 0);
    writeTx(24'h7E81C3);
    waitClk(2);
    monOn = 1'b0;
    drvMaster(24'h9A0B1C, mi, oeSeen, hreqAfter);
    chk("R7 miso word 2", 32'(mi), 32'h007E81C3);
    expW = expRxQ.pop_front();
    chk("R7 rxData slave 2", 32'(rxData), 32'(expW));
    chk("R11 no overrun", 32'(overrun), 32'(mOverrun));

    waitClk(5);
    summary();
    $finish;
  end

endmodule